// File: doc/BRIEF.md
# Skew Delay Code Register Slave

This block is the serial control port of a three-channel skew compensator. It keeps one 6-bit delay code per colour channel (red, green, blue) and shows all three as parallel register outputs, so the delay taps can be steered straight from flops. A host sets or inspects a code with one framed transaction of sixteen bits on a four-wire serial bus: clock, data in, data out and an active-low select.

The serial pins are asynchronous to the block. They are brought into the system clock domain through a synchroniser, and every serial edge is then handled as a one-cycle event. A one-cycle completion strobe marks each frame that reached sixteen bits. An error strobe beside it flags a frame that named the unused channel selector.

The first byte of a frame holds the direction bit in its most significant position and the channel selector in its two lowest bits. The second byte holds the code in its six lowest bits on a write. On a read, the second byte is returned on the data-out pin.

Top module: `skew_code_spi`

## Requirements
- R1: After reset, all three codes are 0, and `sdo_o`, `done_o` and `err_o` are 0.
- R2: A write frame stores bits 5..0 of its second byte in the channel named by selector bits 1..0 of its first byte (00 red, 01 green, 10 blue). The other two channels keep their codes.
- R3: Data-in bits are sampled on rising serial-clock edges, most significant bit first. First-byte bit 7 set to 0 means write and set to 1 means read.
- R4: During the second byte of a read frame, `sdo_o` presents two 0 bits and then the stored 6-bit code, most significant bit first. Each bit is launched after a rising serial-clock edge: the first after edge 8 and the last after edge 15. A read changes no code.
- R5: `sdo_o` is 0 during the first byte of every frame, and it is 0 while the select is high.
- R6: Selector 11 raises `err_o` for one cycle together with `done_o`. A write with selector 11 changes no code, and a read with selector 11 returns all zeros.
- R7: If the select goes high before the sixteenth rising edge, the frame is dropped. No code changes, and neither `done_o` nor `err_o` pulses.
- R8: `done_o` is a single-cycle pulse for each frame that reaches sixteen rising edges. A written code appears on its output in the same cycle as that pulse.
- R9: Rising edges after the sixteenth, while the select stays low, have no effect.
- R10: Bits 7 and 6 of the second byte of a write are ignored.
- R11: If the sixteenth rising edge and the release of the select reach the synchronised domain in the same cycle, the frame still completes. The select must be low for at least one system cycle before the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial read data to the host |
| red_o | output | 6 | Red channel delay code |
| green_o | output | 6 | Green channel delay code |
| blue_o | output | 6 | Blue channel delay code |
| done_o | output | 1 | One-cycle strobe when a full frame completes |
| err_o | output | 1 | One-cycle strobe when a completed frame used selector 11 |

## Verification
The completion of a frame on its sixteenth rising edge and the closing of the frame by the select can land in the same synchronised cycle. The bench provokes this by raising the select in the same time step as the last serial-clock rise, so both pass through equal synchroniser depth. The case is judged at the ports: the written code must appear and exactly one completion strobe must be counted. A separate run raises the select ten bits into a frame and expects neither to happen.

// File: rtl/skew_code_pkg.sv
package skew_code_pkg;
  localparam int BYTE_W     = 8;
  localparam int CODE_W     = 6;
  localparam int SEL_W      = 2;
  localparam int NUM_CH     = 3;
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef enum logic [SEL_W-1:0] {
    SEL_RED = 2'b00,
    SEL_GRN = 2'b01,
    SEL_BLU = 2'b10,
    SEL_BAD = 2'b11
  } chan_sel_e;

  // a selector names a real channel
  function automatic logic sel_ok(input logic [SEL_W-1:0] s);
    return s != SEL_BAD;
  endfunction

  // byte returned on a read: zero padding above the code
  function automatic logic [BYTE_W-1:0] rd_byte(input logic [CODE_W-1:0] c);
    return {{(BYTE_W-CODE_W){1'b0}}, c};
  endfunction
endpackage

// File: rtl/skew_code_sync.sv
module skew_code_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/skew_code_frame.sv
module skew_code_frame
  import skew_code_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic [CODE_W-1:0] rd_code,
  output logic [SEL_W-1:0]  cap_sel,
  output logic              wr_en,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [CODE_W-1:0] wr_code,
  output logic              cs_act,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              sdo,
  output logic              done,
  output logic              err
);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FRM_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] BYTE2_0  = CNT_W'(BYTE_W);

  logic                sck_q, cs_prev;
  logic [BYTE_W-2:0]   shift_q;
  logic [BYTE_W-2:0]   tx_q;
  logic                cmd_rw;
  logic [SEL_W-1:0]    cmd_sel;
  logic [BYTE_W-1:0]   byte_in;
  logic [BYTE_W-1:0]   load_word;
  logic                sck_rise, edge_ok, hdr_edge, last_edge, cap_rw;
  logic                spare_unused;

  assign cs_act    = ~csn_s;
  assign sck_rise  = sck_s & ~sck_q;
  // an edge counts when the select was low in the preceding sample
  assign edge_ok   = sck_rise & cs_prev;
  assign byte_in   = {shift_q, sdi_s};
  assign hdr_edge  = edge_ok && (bit_cnt == HDR_LAST);
  assign last_edge = edge_ok && (bit_cnt == FRM_LAST);
  assign cap_rw    = byte_in[BYTE_W-1];
  assign cap_sel   = byte_in[SEL_W-1:0];
  assign spare_unused = byte_in[BYTE_W-2];
  assign load_word = (cap_rw && sel_ok(cap_sel)) ? rd_byte(rd_code) : '0;

  assign wr_en   = last_edge && !cmd_rw && sel_ok(cmd_sel);
  assign wr_sel  = cmd_sel;
  assign wr_code = byte_in[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cs_prev <= 1'b0;
    end else begin
      sck_q   <= sck_s;
      cs_prev <= cs_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shift_q <= '0;
      tx_q    <= '0;
      cmd_rw  <= 1'b0;
      cmd_sel <= '0;
      sdo     <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (edge_ok && bit_cnt < FRM_FULL) begin
        shift_q <= byte_in[BYTE_W-2:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (hdr_edge) begin
          cmd_rw  <= cap_rw;
          cmd_sel <= cap_sel;
          sdo     <= load_word[BYTE_W-1];
          tx_q    <= load_word[BYTE_W-2:0];
        end else if (last_edge) begin
          sdo  <= 1'b0;
          tx_q <= '0;
          done <= 1'b1;
          err  <= !sel_ok(cmd_sel);
        end else if (bit_cnt >= BYTE2_0) begin
          sdo  <= tx_q[BYTE_W-2];
          tx_q <= {tx_q[BYTE_W-3:0], 1'b0};
        end
      end else if (!cs_act) begin
        bit_cnt <= '0;
        tx_q    <= '0;
        sdo     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/skew_code_regs.sv
module skew_code_regs
  import skew_code_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [CODE_W-1:0] red,
  output logic [CODE_W-1:0] green,
  output logic [CODE_W-1:0] blue,
  output logic [CODE_W-1:0] rd_code
);
  logic [NUM_CH-1:0][CODE_W-1:0] codes;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   codes[ch] <= '0;
        else if (wr_en && wr_sel == SEL_W'(ch))       codes[ch] <= wr_code;
      end
    end
  endgenerate

  assign red   = codes[SEL_RED];
  assign green = codes[SEL_GRN];
  assign blue  = codes[SEL_BLU];

  always_comb begin
    case (rd_sel)
      SEL_RED: rd_code = red;
      SEL_GRN: rd_code = green;
      SEL_BLU: rd_code = blue;
      default: rd_code = '0;
    endcase
  end
endmodule

// File: rtl/skew_code_spi.sv
module skew_code_spi
  import skew_code_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [CODE_W-1:0] red_o,
  output logic [CODE_W-1:0] green_o,
  output logic [CODE_W-1:0] blue_o,
  output logic              done_o,
  output logic              err_o
);
  logic              sck_s, csn_s, sdi_s;
  logic              cs_act;
  logic [CNT_W-1:0]  bit_cnt;
  logic [SEL_W-1:0]  cap_sel, wr_sel;
  logic              wr_en;
  logic [CODE_W-1:0] wr_code, rd_code;

  skew_code_sync #(
    .STAGES (SYNC_STAGES),
    .W      (3),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({sck_i, csn_i, sdi_i}),
    .q_o  ({sck_s, csn_s, sdi_s})
  );

  skew_code_frame u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_s  (sck_s),
    .csn_s  (csn_s),
    .sdi_s  (sdi_s),
    .rd_code(rd_code),
    .cap_sel(cap_sel),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_code(wr_code),
    .cs_act (cs_act),
    .bit_cnt(bit_cnt),
    .sdo    (sdo_o),
    .done   (done_o),
    .err    (err_o)
  );

  skew_code_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_code(wr_code),
    .rd_sel (cap_sel),
    .red    (red_o),
    .green  (green_o),
    .blue   (blue_o),
    .rd_code(rd_code)
  );
endmodule

// File: rtl/skew_code_spi_chk.sv
module skew_code_spi_chk #(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 5,
  parameter int FULL   = 16,
  parameter int HDR    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              sdo_o,
  input logic              done_o,
  input logic              err_o,
  input logic [CODE_W-1:0] red_o,
  input logic [CODE_W-1:0] green_o,
  input logic [CODE_W-1:0] blue_o
);
  a_r5_sdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $past(!cs_act) && $past(!cs_act, 2)) |-> !sdo_o);

  a_r5_sdo_hdr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt < CNT_W'(HDR)) |-> !sdo_o);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bit_cnt == CNT_W'(FULL)));

  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  a_r6_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $stable({red_o, green_o, blue_o}));

  a_r7_codes_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable({red_o, green_o, blue_o}));
endmodule

bind skew_code_spi skew_code_spi_chk u_chk (.*);

// File: tb/skew_code_spi_tb.sv
module skew_code_spi_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic sdo;
  logic [5:0] red, green, blue;
  logic done, err;

  int n_checks = 0, n_fail = 0, n_done = 0, n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skew_code_spi dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .sdi_i(sdi),
    .sdo_o(sdo), .red_o(red), .green_o(green), .blue_o(blue),
    .done_o(done), .err_o(err)
  );

  always @(negedge clk) if (rst_n) begin
    if (done) n_done++;
    if (err)  n_err++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit rw, input logic [1:0] sel,
                                     input logic [7:0] data);
    return {rw, 5'b00000, sel, data};
  endfunction

  task automatic xfer(input logic [15:0] word, input int nbits, input bit cs_with_last,
                      output logic [7:0] rx, output bit quiet);
    rx = '0;
    quiet = 1'b1;
    @(negedge clk) csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? word[15-i] : 1'b1;
      repeat (HALF) @(negedge clk);
      if (i < 8 && sdo !== 1'b0) quiet = 1'b0;
      if (i >= 8 && i < 16) rx[15-i] = sdo;
      sck = 1'b1;
      if (cs_with_last && i == nbits - 1) csn = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    sdi = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    logic [7:0] rx; bit q;
    xfer(mk(1'b0, sel, data), 16, 1'b0, rx, q);
  endtask

  task automatic t_reset;
    check(red == 0 && green == 0 && blue == 0, "R1", "codes after reset", {red, green, blue}, 0);
    check(sdo == 0 && done == 0 && err == 0, "R1", "strobes/sdo after reset", {sdo, done, err}, 0);
  endtask

  task automatic t_writes;
    int d0;
    d0 = n_done;
    wr(2'b00, 8'd10);
    check(red == 10 && green == 0 && blue == 0, "R2", "red write", red, 10);
    wr(2'b01, 8'd20);
    check(green == 20 && red == 10, "R2", "green write", green, 20);
    wr(2'b10, 8'd35);
    check(blue == 35 && red == 10 && green == 20, "R3", "blue write msb first", blue, 35);
    check(n_done - d0 == 3, "R8", "one done per frame", n_done - d0, 3);
  endtask

  task automatic t_dontcare;
    wr(2'b01, 8'hEA);
    check(green == 42, "R10", "upper data bits ignored", green, 42);
  endtask

  task automatic t_read;
    logic [7:0] rx; bit q;
    xfer(mk(1'b1, 2'b10, 8'hFF), 16, 1'b0, rx, q);
    check(rx == 8'd35, "R4", "read blue", rx, 35);
    check(q, "R5", "sdo quiet in first byte", q, 1);
    check(sdo == 0, "R5", "sdo low with select high", sdo, 0);
    check(blue == 35 && red == 10 && green == 42, "R4", "read leaves codes", blue, 35);
    wr(2'b00, 8'd63);
    xfer(mk(1'b1, 2'b00, 8'h00), 16, 1'b0, rx, q);
    check(rx == 8'd63, "R4", "read red max code", rx, 63);
  endtask

  task automatic t_bad_sel;
    logic [7:0] rx; bit q;
    int e0, d0;
    e0 = n_err; d0 = n_done;
    wr(2'b11, 8'd17);
    check(red == 63 && green == 42 && blue == 35, "R6", "write sel 11 changes nothing", red, 63);
    check(n_err - e0 == 1 && n_done - d0 == 1, "R6", "err with done", n_err - e0, 1);
    xfer(mk(1'b1, 2'b11, 8'h00), 16, 1'b0, rx, q);
    check(rx == 0, "R6", "read sel 11 zeros", rx, 0);
    check(n_err - e0 == 2, "R6", "err on bad read", n_err - e0, 2);
  endtask

  task automatic t_abort;
    logic [7:0] rx; bit q;
    int d0, e0;
    d0 = n_done; e0 = n_err;
    xfer(mk(1'b0, 2'b00, 8'd5), 10, 1'b0, rx, q);
    xfer(mk(1'b0, 2'b11, 8'd5), 15, 1'b0, rx, q);
    check(red == 63, "R7", "short frame dropped", red, 63);
    check(n_done == d0 && n_err == e0, "R7", "no strobes on short frame", n_done - d0, 0);
  endtask

  task automatic t_extra;
    logic [7:0] rx; bit q;
    int d0;
    d0 = n_done;
    xfer(mk(1'b0, 2'b10, 8'd7), 22, 1'b0, rx, q);
    check(blue == 7, "R9", "extra edges ignored", blue, 7);
    check(n_done - d0 == 1, "R9", "single done with extra edges", n_done - d0, 1);
  endtask

  task automatic t_coincide;
    logic [7:0] rx; bit q;
    int d0;
    d0 = n_done;
    xfer(mk(1'b0, 2'b00, 8'd50), 16, 1'b1, rx, q);
    check(red == 50, "R11", "last edge with select release commits", red, 50);
    check(n_done - d0 == 1, "R11", "done on coincident close", n_done - d0, 1);
    wr(2'b01, 8'd0);
    check(green == 0 && red == 50 && blue == 7, "R2", "write code 0", green, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_writes;
    t_dontcare;
    t_read;
    t_bad_sel;
    t_abort;
    t_extra;
    t_coincide;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule